// File: doc/BRIEF.md
# Serial Configuration Register Bank with Deferred Commit

This block is a write-only serial slave that takes 8-bit programming words over a chip-select / serial-clock / data-in link. It keeps five configuration fields for a signal-processing front end: a knock-band filter index, a reference-band filter index, a balance gain index, an integrator time-constant code and a test/channel control word. Each word starts with an address prefix whose length decides how wide the value is. A 2-bit prefix carries a 6-bit value. A 3-bit prefix carries a 5-bit value.

A mode input selects hold or integrate. A word that completes while in hold is applied at once. A word that completes while integrating is kept in a single pending slot, and a later word in the same integrate phase replaces it. The pending word is applied when the mode returns to hold. All serial inputs and the mode input are synchronized into the system clock domain, and every register update happens there. The active values are offered as parallel output fields.

Top module: `spi_cfg_bank`

## Requirements
- R1: After reset, all five output fields are zero and no word is pending.
- R2: While `cs_n` is low, one bit of `mosi` is taken on each rising edge of `sclk`. Eight bits form a word, and the first bit taken is bit 7.
- R3: Bits 7:6 of a word select a 6-bit target, and bits 5:0 are the value. `00` selects `knock_idx` (00100111 gives 39), `01` selects `ref_idx` (01001010 gives 10) and `10` selects `bal_idx` (10010100 gives 20).
- R4: Bits 7:5 of a word select a 5-bit target, and bits 4:0 are the value. `110` selects `tc_code` and `111` selects `test_word`.
- R5: With `integ` low (hold), a completed word changes its target field within 4 system clocks after the eighth `sclk` rising edge is synchronized. No other field changes.
- R6: If `cs_n` rises before eight bits arrive, the partial word changes no field. The next `cs_n` assertion starts a fresh word.
- R7: Bits after the eighth within one `cs_n` assertion are ignored.
- R8: While `integ` is high (integrate), no output field changes, even when words arrive.
- R9: A word that completes during integrate is applied when `integ` falls. If several words complete in the same integrate phase, only the last one is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, asynchronous to `clk` |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data in, MSB first |
| integ | input | 1 | Mode: 1 = integrate, 0 = hold |
| knock_idx | output | 6 | Knock-band filter index |
| ref_idx | output | 6 | Reference-band filter index |
| bal_idx | output | 6 | Balance gain index |
| tc_code | output | 5 | Integrator time-constant code |
| test_word | output | 5 | Test / channel control word |

## Verification
A bit counter that slips shows up as a wrong field or a mis-shifted value on the very word that follows it. A counter that failed to restart after an aborted transfer corrupts the next complete word. A pending slot that is not cleared or not overwritten appears only at the end of an integrate phase: a stale value lands on the wrong field, or an older value wins, within a few clocks of `integ` falling. Any leak of a deferred write while integrating shows as a field changing while `integ` is still high.

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank #(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_BITS   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic       integ,
  output logic [5:0] knock_idx,
  output logic [5:0] ref_idx,
  output logic [5:0] bal_idx,
  output logic [4:0] tc_code,
  output logic [4:0] test_word
);
  localparam int CW = $clog2(WORD_BITS + 1);

  logic [SYNC_STAGES:0]   sclk_p, integ_p;
  logic [SYNC_STAGES-1:0] cs_p, mosi_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p  <= '0;
      integ_p <= '0;
      cs_p    <= '1;
      mosi_p  <= '0;
    end else begin
      sclk_p  <= {sclk_p[SYNC_STAGES-1:0], sclk};
      integ_p <= {integ_p[SYNC_STAGES-1:0], integ};
      cs_p    <= {cs_p[SYNC_STAGES-2:0], cs_n};
      mosi_p  <= {mosi_p[SYNC_STAGES-2:0], mosi};
    end
  end

  logic sclk_rise, cs_s, mosi_s, integ_s, integ_fall;
  assign sclk_rise  = sclk_p[SYNC_STAGES-1] & ~sclk_p[SYNC_STAGES];
  assign cs_s       = cs_p[SYNC_STAGES-1];
  assign mosi_s     = mosi_p[SYNC_STAGES-1];
  assign integ_s    = integ_p[SYNC_STAGES-1];
  assign integ_fall = ~integ_s & integ_p[SYNC_STAGES];

  logic [CW-1:0]        bitcnt;
  logic [WORD_BITS-2:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0;
      shreg  <= '0;
    end else if (cs_s) begin
      bitcnt <= '0;
    end else if (sclk_rise && bitcnt < CW'(WORD_BITS)) begin
      shreg  <= {shreg[WORD_BITS-3:0], mosi_s};
      bitcnt <= bitcnt + 1'b1;
    end
  end

  logic                 word_done, direct, commit, pend_vld;
  logic [WORD_BITS-1:0] word, pend_word;

  assign word_done = ~cs_s & sclk_rise & (bitcnt == CW'(WORD_BITS - 1));
  assign word      = {shreg, mosi_s};
  assign direct    = word_done & ~integ_s;
  assign commit    = integ_fall & pend_vld;

  function automatic logic hit(input logic [7:0] w, input logic [2:0] id);
    return (id[2:1] != 2'b11) ? (w[7:6] == id[2:1]) : (w[7:5] == id);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_word <= '0;
    end else if (word_done && integ_s) begin
      pend_vld  <= 1'b1;
      pend_word <= word;
    end else if (commit) begin
      pend_vld  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      knock_idx <= '0;
      ref_idx   <= '0;
      bal_idx   <= '0;
      tc_code   <= '0;
      test_word <= '0;
    end else begin
      if (direct && hit(word, 3'b000))           knock_idx <= word[5:0];
      else if (commit && hit(pend_word, 3'b000)) knock_idx <= pend_word[5:0];
      if (direct && hit(word, 3'b010))           ref_idx   <= word[5:0];
      else if (commit && hit(pend_word, 3'b010)) ref_idx   <= pend_word[5:0];
      if (direct && hit(word, 3'b100))           bal_idx   <= word[5:0];
      else if (commit && hit(pend_word, 3'b100)) bal_idx   <= pend_word[5:0];
      if (direct && hit(word, 3'b110))           tc_code   <= word[4:0];
      else if (commit && hit(pend_word, 3'b110)) tc_code   <= pend_word[4:0];
      if (direct && hit(word, 3'b111))           test_word <= word[4:0];
      else if (commit && hit(pend_word, 3'b111)) test_word <= pend_word[4:0];
    end
  end
endmodule

// File: rtl/spi_cfg_bank_chk.sv
module spi_cfg_bank_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          integ_s,
  input logic          integ_fall,
  input logic          cs_s,
  input logic          pend_vld,
  input logic [CW-1:0] bitcnt,
  input logic [27:0]   outs
);
  a_r8_frozen_in_integ: assert property (@(posedge clk) disable iff (!rst_n)
    integ_s |=> $stable(outs));

  a_r9_pend_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (integ_fall && pend_vld) |=> !pend_vld);

  a_r6_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (bitcnt == '0));

  a_r7_cnt_capped: assert property (@(posedge clk) disable iff (!rst_n)
    (bitcnt == CW'(8) && !cs_s) |=> (bitcnt == CW'(8)));

  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= CW'(8));
endmodule

bind spi_cfg_bank spi_cfg_bank_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .integ_s(integ_s), .integ_fall(integ_fall),
  .cs_s(cs_s), .pend_vld(pend_vld), .bitcnt(bitcnt),
  .outs({knock_idx, ref_idx, bal_idx, tc_code, test_word})
);

// File: tb/tb_spi_cfg_bank.sv
`timescale 1ns/1ps
module tb_spi_cfg_bank;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, integ = 1'b0;
  logic [5:0] knock_idx, ref_idx, bal_idx;
  logic [4:0] tc_code, test_word;
  int checks = 0, errors = 0, cycles = 0;

  always #2.5 clk = ~clk;

  spi_cfg_bank dut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .integ(integ), .knock_idx(knock_idx), .ref_idx(ref_idx),
    .bal_idx(bal_idx), .tc_code(tc_code), .test_word(test_word));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] bits, input int n);
    cs_n = 1'b0; idle(4);
    for (int i = 0; i < n; i++) begin
      mosi = bits[15 - i]; idle(4);
      sclk = 1'b1; idle(4);
      sclk = 1'b0;
    end
    idle(4); cs_n = 1'b1; idle(8);
  endtask

  task automatic expect_all(input string req, input int k, input int r,
                            input int b, input int t, input int w);
    chk({req, " knock"}, knock_idx, k);
    chk({req, " ref"},   ref_idx,   r);
    chk({req, " bal"},   bal_idx,   b);
    chk({req, " tc"},    tc_code,   t);
    chk({req, " test"},  test_word, w);
  endtask

  task automatic t_reset;
    idle(3); rst_n = 1'b1; idle(3);
    expect_all("R1", 0, 0, 0, 0, 0);
  endtask

  task automatic t_hold_writes;
    send({8'b00100111, 8'h0}, 8); expect_all("R3 R5", 39, 0, 0, 0, 0);
    send({8'b01001010, 8'h0}, 8); expect_all("R3 R5", 39, 10, 0, 0, 0);
    send({8'b10010100, 8'h0}, 8); expect_all("R3 R2", 39, 10, 20, 0, 0);
    send({8'b11010110, 8'h0}, 8); expect_all("R4", 39, 10, 20, 22, 0);
    send({8'b11110011, 8'h0}, 8); expect_all("R4", 39, 10, 20, 22, 19);
  endtask

  task automatic t_partial;
    send({8'b00111111, 8'h0}, 5); expect_all("R6 partial", 39, 10, 20, 22, 19);
    send({8'b01000011, 8'h0}, 8); expect_all("R6 restart", 39, 3, 20, 22, 19);
  endtask

  task automatic t_extra_bits;
    send({8'b10000101, 8'b11000000}, 10); expect_all("R7", 39, 3, 5, 22, 19);
  endtask

  task automatic t_integrate;
    integ = 1'b1; idle(8);
    send({8'b00000101, 8'h0}, 8); expect_all("R8 first", 39, 3, 5, 22, 19);
    send({8'b01000111, 8'h0}, 8); expect_all("R8 second", 39, 3, 5, 22, 19);
    integ = 1'b0; idle(8);
    expect_all("R9 commit last only", 39, 7, 5, 22, 19);
    send({8'b11000001, 8'h0}, 8); expect_all("R9 no recommit R5", 39, 7, 5, 1, 19);
  endtask

  task automatic t_integrate_5bit;
    integ = 1'b1; idle(8);
    send({8'b11101010, 8'h0}, 8); expect_all("R8 test word", 39, 7, 5, 1, 19);
    integ = 1'b0; idle(8);
    expect_all("R9 R4 commit", 39, 7, 5, 1, 10);
  endtask

  initial begin
    t_reset;
    t_hold_writes;
    t_partial;
    t_extra_bits;
    t_integrate;
    t_integrate_5bit;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule